// File: doc/BRIEF.md
# Software Transfer Trigger Register

This block is a small control register through which the CPU starts a data-transfer engine without any hardware event. It holds a 1-bit arm flag (bit 7) and a 7-bit channel vector (bits 6..0). The vector is turned into a descriptor address. That address is the vector shifted left by one, added to a fixed base of 0x0400.

When the arm flag is set and no transfer is in flight, the block sends a one-cycle start request to the engine. It then waits for the engine's completion report. The report carries two flags: the interrupt-disable select and count exhausted. They decide whether the arm flag drops by itself or stays set.

When the arm flag stays set, the block raises an end interrupt that is held until the CPU acknowledges it. While the flag is left set, the CPU re-arms the block by writing 0 to the disable-select bit. That write clears the arm flag.

Top module: `sw_xfer_trigger`

## Requirements
- R1: After reset, and one cycle after a standby pulse, the read value is 0x00, the start request is 0 and the end interrupt is 0.
- R2: A CPU write with bit 7 = 1 sets the arm flag. A CPU write with bit 7 = 0 leaves the arm flag unchanged.
- R3: While the arm flag is 1, CPU writes leave bits 6..0 unchanged. While it is 0, a write loads bits 6..0 from the write data.
- R4: The vector address always equals 0x0400 + (bits 6..0 << 1), for example 0x0420 for vector 0x10.
- R5: The start request is 1 for exactly one cycle once the arm flag is set and no transfer is in flight. It is 1 only while the arm flag is 1. It does not repeat until a completion is reported.
- R6: The arm flag stays 1 for as long as a started transfer has not reported completion.
- R7: A completion with disable-select 0 and count-exhausted 0 clears the arm flag one cycle later and raises no interrupt.
- R8: A completion with disable-select 1 or count-exhausted 1 keeps the arm flag at 1 and raises the end interrupt. No new start request follows.
- R9: The end interrupt stays 1 until an acknowledge is applied. It drops one cycle after the acknowledge.
- R10: With the arm flag left set after an end interrupt, a disable-select write of 0 clears the arm flag. A disable-select write of 1 does not.
- R11: When a hardware clear (R7 or R10) and a CPU write with bit 7 = 1 fall in the same cycle, the arm flag ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby | input | 1 | Hardware standby, synchronously clears all state |
| cpu_wr | input | 1 | CPU write strobe for the register |
| cpu_wdata | input | VEC_W+1 (8) | CPU write data: bit 7 arm flag, bits 6..0 vector |
| cpu_rdata | output | VEC_W+1 (8) | Current register value |
| dsel_wr | input | 1 | CPU write strobe for the disable-select bit |
| dsel_wdata | input | 1 | Value written to the disable-select bit |
| xfer_done | input | 1 | Engine reports the transfer finished |
| xfer_dsel | input | 1 | Disable-select flag of the finished transfer |
| xfer_cnt_zero | input | 1 | Transfer count exhausted on the finished transfer |
| start_req | output | 1 | One-cycle start request to the engine |
| vec_addr | output | ADDR_W (16) | Descriptor address derived from the vector |
| end_irq | output | 1 | Software-transfer end interrupt, pending until acknowledged |
| irq_ack | input | 1 | CPU acknowledge of the end interrupt |

## Verification
Register contents, the end interrupt and the arm-flag clears all appear one clock edge after the stimulus. The vector address follows the register with no further delay. The start request rises in the same cycle the arm flag first reads as 1 and falls one edge later. The bench changes inputs at the falling edge and samples at the next falling edge. Each check therefore lands one edge after its stimulus, or two edges for the start request's drop. Random vectors and random completion flags are compared against bench functions that compute the expected address and the expected hold-or-clear outcome.

// File: rtl/sxa_pkg.sv
package sxa_pkg;
  // outcome of a completion report from the engine
  typedef enum logic [1:0] {
    END_NONE  = 2'd0,
    END_CLEAR = 2'd1,
    END_HOLD  = 2'd2
  } end_cause_e;
endpackage

// File: rtl/sxa_reg.sv
module sxa_reg #(
  parameter int VEC_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stby,
  input  logic             cpu_wr,
  input  logic [VEC_W:0]   cpu_wdata,
  input  logic             hw_clr,
  output logic             en_o,
  output logic [VEC_W-1:0] vec_o
);
  logic             en_q, en_d, en_ce;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             vec_ce;

  always_comb begin
    // arm flag: only CPU sets, hardware clear wins
    en_ce  = stby | hw_clr | (cpu_wr & cpu_wdata[VEC_W]);
    en_d   = ~(stby | hw_clr);
    // vector: writable only while disarmed
    vec_ce = stby | (cpu_wr & ~en_q);
    vec_d  = stby ? '0 : cpu_wdata[VEC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      vec_q <= '0;
    end else begin
      if (en_ce)  en_q  <= en_d;
      if (vec_ce) vec_q <= vec_d;
    end
  end

  assign en_o  = en_q;
  assign vec_o = vec_q;
endmodule

// File: rtl/sxa_seq.sv
module sxa_seq
  import sxa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stby,
  input  logic en,
  input  logic xfer_done,
  input  logic xfer_dsel,
  input  logic xfer_cnt_zero,
  input  logic dsel_wr,
  input  logic dsel_wdata,
  input  logic irq_ack,
  output logic start_req,
  output logic hw_clr,
  output logic end_irq
);
  logic       busy_q, busy_d;
  logic       held_q, held_d;
  logic       irq_q, irq_d;
  logic       rearm_clr;
  end_cause_e cause;

  always_comb begin
    cause = END_NONE;
    if (busy_q && xfer_done)
      cause = (xfer_dsel || xfer_cnt_zero) ? END_HOLD : END_CLEAR;
    start_req = en & ~busy_q & ~held_q & ~stby;
    rearm_clr = held_q & dsel_wr & ~dsel_wdata;
    hw_clr    = (cause == END_CLEAR) | rearm_clr;

    busy_d = busy_q;
    if (stby)                  busy_d = 1'b0;
    else if (start_req)        busy_d = 1'b1;
    else if (cause != END_NONE) busy_d = 1'b0;

    held_d = held_q;
    if (stby)                  held_d = 1'b0;
    else if (cause == END_HOLD) held_d = 1'b1;
    else if (rearm_clr)        held_d = 1'b0;

    irq_d = irq_q;
    if (stby)                  irq_d = 1'b0;
    else if (cause == END_HOLD) irq_d = 1'b1;
    else if (irq_ack)          irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      held_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      held_q <= held_d;
      irq_q  <= irq_d;
    end
  end

  assign end_irq = irq_q;
endmodule

// File: rtl/sxa_addr.sv
module sxa_addr #(
  parameter int               VEC_W  = 7,
  parameter int               ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE  = 16'h0400
) (
  input  logic [VEC_W-1:0]  vec,
  output logic [ADDR_W-1:0] addr
);
  localparam int PAD = ADDR_W - VEC_W - 1;

  generate
    if (PAD > 0) begin : g_pad
      assign addr = BASE + {{PAD{1'b0}}, vec, 1'b0};
    end else begin : g_nopad
      assign addr = BASE + ADDR_W'({vec, 1'b0});
    end
  endgenerate
endmodule

// File: rtl/sw_xfer_trigger.sv
module sw_xfer_trigger #(
  parameter int               VEC_W  = 7,
  parameter int               ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE  = 16'h0400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stby,
  input  logic              cpu_wr,
  input  logic [VEC_W:0]    cpu_wdata,
  output logic [VEC_W:0]    cpu_rdata,
  input  logic              dsel_wr,
  input  logic              dsel_wdata,
  input  logic              xfer_done,
  input  logic              xfer_dsel,
  input  logic              xfer_cnt_zero,
  output logic              start_req,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              end_irq,
  input  logic              irq_ack
);
  logic             rst_meta_q, rst_sync_q;
  logic             en, hw_clr;
  logic [VEC_W-1:0] vec;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  sxa_reg #(.VEC_W(VEC_W)) u_reg (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .stby      (stby),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .hw_clr    (hw_clr),
    .en_o      (en),
    .vec_o     (vec)
  );

  sxa_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_sync_q),
    .stby          (stby),
    .en            (en),
    .xfer_done     (xfer_done),
    .xfer_dsel     (xfer_dsel),
    .xfer_cnt_zero (xfer_cnt_zero),
    .dsel_wr       (dsel_wr),
    .dsel_wdata    (dsel_wdata),
    .irq_ack       (irq_ack),
    .start_req     (start_req),
    .hw_clr        (hw_clr),
    .end_irq       (end_irq)
  );

  sxa_addr #(.VEC_W(VEC_W), .ADDR_W(ADDR_W), .BASE(BASE)) u_addr (
    .vec  (vec),
    .addr (vec_addr)
  );

  assign cpu_rdata = {en, vec};
endmodule

// File: rtl/sxa_chk.sv
module sxa_chk #(
  parameter int               VEC_W  = 7,
  parameter int               ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE  = 16'h0400
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stby,
  input logic [VEC_W:0]    cpu_rdata,
  input logic              start_req,
  input logic [ADDR_W-1:0] vec_addr,
  input logic              end_irq,
  input logic              irq_ack
);
  localparam int PAD = ADDR_W - VEC_W - 1;

  // R1
  standby_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stby |=> (cpu_rdata == '0 && !end_irq));

  // R3
  vec_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rdata[VEC_W] && !stby) |=> (cpu_rdata[VEC_W-1:0] == $past(cpu_rdata[VEC_W-1:0])));

  // R4
  addr_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_addr == BASE + {{PAD{1'b0}}, cpu_rdata[VEC_W-1:0], 1'b0});

  // R5
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> !start_req);

  // R5
  req_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> cpu_rdata[VEC_W]);

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (end_irq && !irq_ack && !stby) |=> end_irq);
endmodule

bind sw_xfer_trigger sxa_chk #(.VEC_W(VEC_W), .ADDR_W(ADDR_W), .BASE(BASE)) u_sxa_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stby      (stby),
  .cpu_rdata (cpu_rdata),
  .start_req (start_req),
  .vec_addr  (vec_addr),
  .end_irq   (end_irq),
  .irq_ack   (irq_ack)
);

// File: tb/test_sw_xfer_trigger.sv
module test_sw_xfer_trigger;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stby = 1'b0, cpu_wr = 1'b0, dsel_wr = 1'b0, dsel_wdata = 1'b0;
  logic        xfer_done = 1'b0, xfer_dsel = 1'b0, xfer_cnt_zero = 1'b0, irq_ack = 1'b0;
  logic [7:0]  cpu_wdata = 8'h00;
  logic [7:0]  cpu_rdata;
  logic        start_req, end_irq;
  logic [15:0] vec_addr;
  int          total = 0, bad = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  sw_xfer_trigger i_sw_xfer_trigger (
    .clk(clk), .rst_n(rst_n), .stby(stby), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .dsel_wr(dsel_wr), .dsel_wdata(dsel_wdata),
    .xfer_done(xfer_done), .xfer_dsel(xfer_dsel), .xfer_cnt_zero(xfer_cnt_zero),
    .start_req(start_req), .vec_addr(vec_addr), .end_irq(end_irq), .irq_ack(irq_ack)
  );

  function automatic logic [15:0] exp_addr(input logic [6:0] v);
    return 16'h0400 + {8'h00, v, 1'b0};
  endfunction

  function automatic logic exp_keep(input logic ds, input logic cz);
    return ds | cz;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    cpu_wr = 1'b1; cpu_wdata = d;
    step();
    cpu_wr = 1'b0;
  endtask

  task automatic done(input logic ds, input logic cz);
    xfer_done = 1'b1; xfer_dsel = ds; xfer_cnt_zero = cz;
    step();
    xfer_done = 1'b0; xfer_dsel = 1'b0; xfer_cnt_zero = 1'b0;
  endtask

  task automatic dsel(input logic v);
    dsel_wr = 1'b1; dsel_wdata = v;
    step();
    dsel_wr = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    step();
    irq_ack = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    step(); step(); step();
    // R1 reset state
    chk("R1 rdata", cpu_rdata, 8'h00);
    chk("R1 req", start_req, 1'b0);
    chk("R1 irq", end_irq, 1'b0);

    // R3 vector load while disarmed, R4 address
    wr(8'h10);
    chk("R3 load", cpu_rdata, 8'h10);
    chk("R4 addr", vec_addr, 16'h0420);

    // R2 arm, R5 pulse
    wr(8'h90);
    chk("R2 arm", cpu_rdata, 8'h90);
    chk("R5 req rise", start_req, 1'b1);
    step();
    chk("R5 req drop", start_req, 1'b0);
    wr(8'h05);
    chk("R3 locked", cpu_rdata, 8'h90);
    wr(8'h00);
    chk("R2 write0", cpu_rdata, 8'h90);
    repeat (5) step();
    chk("R6 held", cpu_rdata[7], 1'b1);
    chk("R5 no rereq", start_req, 1'b0);

    // R7 normal completion
    done(1'b0, 1'b0);
    chk("R7 clear", cpu_rdata, 8'h10);
    chk("R7 no irq", end_irq, 1'b0);

    // R8 disable-select completion
    wr(8'h83);
    chk("R5 req", start_req, 1'b1);
    step();
    done(1'b1, 1'b0);
    chk("R8 kept", cpu_rdata, 8'h83);
    chk("R8 irq", end_irq, 1'b1);
    repeat (3) step();
    chk("R8 no req", start_req, 1'b0);
    chk("R9 pending", end_irq, 1'b1);
    ack();
    chk("R9 acked", end_irq, 1'b0);
    dsel(1'b1);
    chk("R10 dsel1", cpu_rdata[7], 1'b1);
    dsel(1'b0);
    chk("R10 dsel0", cpu_rdata, 8'h03);

    // R8 count exhausted, then R11 rearm clear vs CPU set
    wr(8'h81);
    step();
    done(1'b0, 1'b1);
    chk("R8 cnt kept", cpu_rdata, 8'h81);
    chk("R8 cnt irq", end_irq, 1'b1);
    ack();
    dsel_wr = 1'b1; dsel_wdata = 1'b0;
    wr(8'h80);
    dsel_wr = 1'b0;
    chk("R11 rearm", cpu_rdata, 8'h01);

    // R11 normal completion vs CPU set
    wr(8'h82);
    step();
    xfer_done = 1'b1;
    wr(8'h80);
    xfer_done = 1'b0;
    chk("R11 done", cpu_rdata, 8'h02);

    // R1 standby
    wr(8'h85);
    step();
    done(1'b1, 1'b1);
    stby = 1'b1;
    step();
    stby = 1'b0;
    chk("R1 stby rdata", cpu_rdata, 8'h00);
    chk("R1 stby irq", end_irq, 1'b0);
    chk("R1 stby req", start_req, 1'b0);

    // random rounds
    for (int i = 0; i < 40; i++) begin
      logic [6:0] v;
      logic ds, cz;
      v  = 7'($urandom % 128);
      ds = 1'($urandom % 2);
      cz = 1'($urandom % 2);
      wr({1'b0, v});
      chk("R4 rnd addr", vec_addr, exp_addr(v));
      wr({1'b1, ~v});
      chk("R3 rnd load", cpu_rdata, {1'b1, ~v});
      chk("R5 rnd req", start_req, 1'b1);
      step();
      wr({1'b0, v});
      chk("R3 rnd lock", cpu_rdata, {1'b1, ~v});
      done(ds, cz);
      chk("R8 rnd arm", cpu_rdata[7], exp_keep(ds, cz));
      chk("R8 rnd irq", end_irq, exp_keep(ds, cz));
      chk("R4 rnd addr2", vec_addr, exp_addr(~v));
      if (exp_keep(ds, cz)) begin
        ack();
        dsel(1'b0);
        chk("R10 rnd", cpu_rdata[7], 1'b0);
      end
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule